// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the interrupt bookkeeping of a small peripheral adapter. Three event sources (a byte shifter, a first timer and a second timer) each raise a one-cycle pulse; the pulse sets a sticky flag bit that stays set until software clears it. A separate enable register masks the flags. The block drives one active-high interrupt line. That line follows only the shifter and first-timer flags, and only when their enables are set.

Software reaches the block through a byte-wide register port with a 4-bit offset, a write strobe and a read strobe. The flag register sits at offset 13 and the enable register at offset 14. Bit 7 of both has a special meaning.

- A flag read reports in bit 7 whether any enabled flag is pending.
- An enable read always shows bit 7 as 1.
- An enable write uses bit 7 to choose between setting and clearing the marked bits.

Reads of three data offsets also clear one flag each, as a side effect. The timers and the shifter sit outside this block; only their flag-raising pulses and the offsets of their data registers come in here.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and enables are 0, `irq_o` is 0, a read of offset 13 returns 0x00 and a read of offset 14 returns 0x80.
- R2: A pulse on `sr_set_i`, `t2_set_i` or `t1_set_i` sets flag bit 2, bit 5 or bit 6 respectively from the next clock on, and the bit stays set until cleared. Flag bits 0, 1, 3 and 4 always read 0.
- R3: A read of offset 13 returns the flags in bits [6:0]. Bit 7 is 1 exactly when the AND of flags and enables in bits [6:0] is nonzero.
- R4: A read of offset 14 returns the enables in bits [6:0], with bit 7 always 1.
- R5: A write to offset 14 with bit 7 = 1 sets the enable bits marked by 1 in data [6:0]. With bit 7 = 0 the write clears those bits instead. Enable bits not marked keep their value.
- R6: `irq_o` is 1 one clock after (flags AND enables) has bit 2 or bit 6 set, and 0 one clock after neither is set. Flag bit 5 never drives `irq_o`.
- R7: A read strobe at offset 10 clears flag bit 2, one at offset 4 clears bit 6, and one at offset 8 clears bit 5. A read strobe at any other offset leaves the flags unchanged.
- R8: A write to offset 13 clears every flag whose data bit in [6:0] is 1. Data bit 7 of that write is ignored.
- R9: When a set pulse and a clear (read strobe or flag write) hit the same flag in one cycle, the flag ends up set.
- R10: A read of any offset other than 13 and 14 returns 0x00 on `reg_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_set_i | input | 1 | Shifter event pulse, sets flag bit 2 |
| t1_set_i | input | 1 | First-timer event pulse, sets flag bit 6 |
| t2_set_i | input | 1 | Second-timer event pulse, sets flag bit 5 |
| reg_addr_i | input | 4 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe, drives side-effect clears |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from offset |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The main sweep covers every combination of the three set pulses against every one of the 128 enable patterns. Each combination is checked on the summary bit of the flag read, the constant bit 7 of the enable read and the interrupt line. This separates a summary that wrongly leaves out the second timer from an interrupt line that wrongly includes it.

Further directed patterns cover the following:
- read strobes at all sixteen offsets, which tells a correct clearing offset from a wrong one;
- enable writes in both modes over a partly set register, which shows whether unmarked bits are disturbed;
- write-one-to-clear with bit 7 set;
- a set pulse landing in the same cycle as each kind of clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned FLAG_W = DATA_W - 1;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned SRC_N  = 3;

    // source index: 0 = shifter, 1 = second timer, 2 = first timer
    localparam logic [SRC_N-1:0][ADDR_W-1:0] SRC_BIT     = {4'd6, 4'd5, 4'd2};
    localparam logic [SRC_N-1:0][ADDR_W-1:0] SRC_CLR_OFS = {4'd4, 4'd8, 4'd10};
    localparam logic [SRC_N-1:0]             SRC_TO_IRQ  = 3'b101;

    localparam logic [ADDR_W-1:0] FLAG_OFS = 4'd13;
    localparam logic [ADDR_W-1:0] EN_OFS   = 4'd14;

    function automatic logic [FLAG_W-1:0] irq_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (SRC_TO_IRQ[i]) m[SRC_BIT[i]] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic [FLAG_W-1:0] bits;
    } vec_state_t;

    typedef struct packed {
        logic irq;
    } out_state_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_ctrl_pkg::*;
(
    input  logic [SRC_N-1:0]  src_set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flag_set_o,
    output logic [FLAG_W-1:0] flag_clr_o,
    output logic [FLAG_W-1:0] en_set_o,
    output logic [FLAG_W-1:0] en_clr_o
);
    always_comb begin
        flag_set_o = '0;
        flag_clr_o = '0;
        en_set_o   = '0;
        en_clr_o   = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (src_set_i[i]) flag_set_o[SRC_BIT[i]] = 1'b1;
            if (rd_i && (addr_i == SRC_CLR_OFS[i])) flag_clr_o[SRC_BIT[i]] = 1'b1;
        end
        if (wr_i && (addr_i == FLAG_OFS)) begin
            flag_clr_o = flag_clr_o | wdata_i[FLAG_W-1:0];
        end
        if (wr_i && (addr_i == EN_OFS)) begin
            if (wdata_i[DATA_W-1]) en_set_o = wdata_i[FLAG_W-1:0];
            else                   en_clr_o = wdata_i[FLAG_W-1:0];
        end
    end
endmodule

// File: rtl/irq_bit_reg.sv
module irq_bit_reg
    import irq_ctrl_pkg::*;
#(
    parameter logic [FLAG_W-1:0] KEEP_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] q_o
);
    vec_state_t st_d, st_q;

    // set takes priority over clear in the same cycle
    always_comb begin
        st_d.bits = ((st_q.bits & ~clr_i) | set_i) & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_set_i,
    input  logic              t1_set_i,
    input  logic              t2_set_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam logic [FLAG_W-1:0] IRQ_MASK = irq_mask();

    function automatic logic [FLAG_W-1:0] src_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        for (int i = 0; i < SRC_N; i++) m[SRC_BIT[i]] = 1'b1;
        return m;
    endfunction
    localparam logic [FLAG_W-1:0] FLAG_MASK = src_mask();

    logic [SRC_N-1:0]  src_set;
    logic [FLAG_W-1:0] flag_set, flag_clr, en_set, en_clr;
    logic [FLAG_W-1:0] flag_q, en_q;
    logic              pending;
    out_state_t        out_d, out_q;

    assign src_set = {t1_set_i, t2_set_i, sr_set_i};

    irq_reg_decode u_decode (
        .src_set_i  (src_set),
        .addr_i     (reg_addr_i),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .wdata_i    (reg_wdata_i),
        .flag_set_o (flag_set),
        .flag_clr_o (flag_clr),
        .en_set_o   (en_set),
        .en_clr_o   (en_clr)
    );

    irq_bit_reg #(.KEEP_MASK(FLAG_MASK)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flag_q)
    );

    irq_bit_reg #(.KEEP_MASK('1)) u_enables (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .q_o   (en_q)
    );

    assign pending = |(flag_q & en_q);

    always_comb begin
        case (reg_addr_i)
            FLAG_OFS: reg_rdata_o = {pending, flag_q};
            EN_OFS:   reg_rdata_o = {1'b1, en_q};
            default:  reg_rdata_o = '0;
        endcase
    end

    always_comb begin
        out_d.irq = |(flag_q & en_q & IRQ_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o = out_q.irq;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sr_set_i,
    input logic              t1_set_i,
    input logic              t2_set_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [FLAG_W-1:0] flag_q,
    input logic [FLAG_W-1:0] en_q
);
    logic en_wr;
    assign en_wr = reg_wr_i && (reg_addr_i == EN_OFS);

    assert_sr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr_set_i |=> flag_q[2]);

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q & 7'h1B) == 7'h00);

    assert_flag_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == FLAG_OFS) |-> (reg_rdata_o[7] == (|(flag_q & en_q))));

    assert_en_bit7_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == EN_OFS) |-> reg_rdata_o[7]);

    assert_en_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && reg_wdata_i[7]) |=> ((en_q & $past(reg_wdata_i[6:0])) == $past(reg_wdata_i[6:0])));

    assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !reg_wdata_i[7]) |=> ((en_q & $past(reg_wdata_i[6:0])) == 7'h00));

    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(flag_q & en_q & 7'h44))));

    assert_t1_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_set_i && reg_rd_i && reg_addr_i == 4'd4) |=> flag_q[6]);

    assert_t2_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t2_set_i |=> flag_q[5]);

    assert_other_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i != FLAG_OFS && reg_addr_i != EN_OFS) |-> (reg_rdata_o == 8'h00));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sr_set_i    (sr_set_i),
    .t1_set_i    (t1_set_i),
    .t2_set_i    (t2_set_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .flag_q      (flag_q),
    .en_q        (en_q)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_set = 1'b0, t1_set = 1'b0, t2_set = 1'b0;
    logic [3:0] addr = 4'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] exp_flag = 7'h00;
    logic [6:0] exp_en   = 7'h00;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_set_i    (sr_set),
        .t1_set_i    (t1_set),
        .t2_set_i    (t2_set),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
        if (a == 4'd13) exp_flag = exp_flag & ~d[6:0];
        if (a == 4'd14) exp_en = d[7] ? (exp_en | d[6:0]) : (exp_en & ~d[6:0]);
    endtask

    task automatic rd_strobe(input logic [3:0] a);
        addr = a; rd = 1'b1;
        tick();
        rd = 1'b0;
        if (a == 4'd10) exp_flag[2] = 1'b0;
        if (a == 4'd4)  exp_flag[6] = 1'b0;
        if (a == 4'd8)  exp_flag[5] = 1'b0;
    endtask

    // bit0 shifter, bit1 second timer, bit2 first timer
    task automatic pulse(input logic [2:0] s);
        sr_set = s[0]; t2_set = s[1]; t1_set = s[2];
        tick();
        sr_set = 1'b0; t2_set = 1'b0; t1_set = 1'b0;
        if (s[0]) exp_flag[2] = 1'b1;
        if (s[1]) exp_flag[5] = 1'b1;
        if (s[2]) exp_flag[6] = 1'b1;
    endtask

    task automatic check_reads(input string rq);
        addr = 4'd13; #1;
        check({rq, " R3 flag read"}, rdata, {|(exp_flag & exp_en), exp_flag});
        addr = 4'd14; #1;
        check({rq, " R4 enable read"}, rdata, {1'b1, exp_en});
    endtask

    task automatic check_irq(input string rq);
        tick();
        check({rq, " R6 irq"}, {7'h0, irq}, {7'h0, |(exp_flag & exp_en & 7'h44)});
    endtask

    task automatic clear_all();
        wr_reg(4'd14, 8'h7F);
        wr_reg(4'd13, 8'h7F);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state while held and after release
        check("R1 irq in reset", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();
        addr = 4'd13; #1;
        check("R1 flag read", rdata, 8'h00);
        addr = 4'd14; #1;
        check("R1 enable read", rdata, 8'h80);
        check("R1 irq", {7'h0, irq}, 8'h00);

        // R2 R3 R4 R6 exhaustive sweep of sources x enables
        for (int f = 0; f < 8; f++) begin
            for (int e = 0; e < 128; e++) begin
                clear_all();
                pulse(f[2:0]);
                wr_reg(4'd14, {1'b1, e[6:0]});
                check_reads("R2 sweep");
                check_irq("R2 sweep");
            end
        end

        // R2 sticky: flag holds over idle cycles
        clear_all();
        pulse(3'b001);
        repeat (5) tick();
        addr = 4'd13; #1;
        check("R2 sticky", rdata, 8'h04);

        // R7 read strobes at every offset
        for (int a = 0; a < 16; a++) begin
            clear_all();
            wr_reg(4'd14, 8'hFF);
            pulse(3'b111);
            rd_strobe(a[3:0]);
            check_reads("R7 strobe");
            check_irq("R7 strobe");
        end

        // R10 other offsets read zero
        for (int a = 0; a < 16; a++) begin
            if (a != 13 && a != 14) begin
                addr = a[3:0]; #1;
                check("R10 other offset", rdata, 8'h00);
            end
        end

        // R5 enable clear and set modes leave unmarked bits alone
        clear_all();
        wr_reg(4'd14, 8'hFF);
        wr_reg(4'd14, 8'h05);
        check_reads("R5 clear mode");
        check("R5 clear value", {1'b0, exp_en}, 8'h7A);
        wr_reg(4'd14, 8'h81);
        check_reads("R5 set mode");
        check("R5 set value", {1'b0, exp_en}, 8'h7B);

        // R8 write-one-to-clear, bit 7 ignored
        pulse(3'b111);
        wr_reg(4'd13, 8'hE0);
        check_reads("R8 w1c");
        check("R8 remaining", {1'b0, exp_flag}, 8'h04);
        wr_reg(4'd13, 8'h80);
        check_reads("R8 bit7 only");

        // R6 second timer alone never raises irq
        clear_all();
        wr_reg(4'd14, 8'hFF);
        pulse(3'b010);
        check_irq("R6 t2 only");
        check("R6 t2 summary", rdata, {1'b1, 7'h7F});

        // R9 set wins over read strobe and over flag write
        clear_all();
        wr_reg(4'd14, 8'hFF);
        t1_set = 1'b1; addr = 4'd4; rd = 1'b1;
        tick();
        t1_set = 1'b0; rd = 1'b0;
        addr = 4'd13; #1;
        check("R9 set wins over strobe", rdata, 8'hC0);
        sr_set = 1'b1; addr = 4'd13; wdata = 8'h7F; wr = 1'b1;
        tick();
        sr_set = 1'b0; wr = 1'b0;
        addr = 4'd13; #1;
        check("R9 set wins over w1c", rdata, 8'h84);
        tick();
        check("R9 irq", {7'h0, irq}, 8'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule